// File: doc/BRIEF.md
# Dual Radix-2 Butterfly Pipeline

This block computes two fixed-point radix-2 butterflies per pass. Each butterfly takes complex operands A and B and a complex twiddle C. It returns R = A + B and S = (A − B)·C. A pass is made of four step commands issued in a fixed order. The first two steps each bring in one 128-bit word of operands. The last two steps each send out one 128-bit word of results. The memory port therefore moves one word on every step.

A single arithmetic slice holds exactly two signed multipliers and is shared across the four steps. Each step produces one output component (real or imaginary) of one butterfly, and both multipliers are busy in every step.

The operand path has two register stages. An input shadow stage collects the next operands while the working stage feeds the arithmetic. A result buffer holds the previous pass's results while the current pass computes new ones. Operands loaded in one pass are computed in the next pass and stored in the pass after that. A step issued out of order is rejected and flagged, and it changes nothing.

Top module: `bfly2_pipe`

## Requirements
- R1: After reset, `st_valid`, `seq_err` and `st_data` are zero, and the block expects a load-A step. All operand and result buffers start at zero, so the stores of the first two passes return all-zero words.
- R2: The `step_cmd` codes are: 0 = load A pair, 1 = load B pair, 2 = store R pair, 3 = store S pair. A step is accepted only when `step_valid` is high and its code is the next one in the cycle 0,1,2,3,0,… A cycle with `step_valid` low is idle and changes nothing.
- R3: A step with `step_valid` high and a code other than the expected one is rejected. `seq_err` is then high for exactly the following cycle. The rejected step loads nothing, computes nothing and stores nothing: `st_valid` stays low, `st_data` holds its value, and the expected code does not change.
- R4: A 128-bit word has four 32-bit lanes. Lane 0 (bits 31:0) holds the real part of butterfly 0. Lane 1 holds the imaginary part of butterfly 0. Lane 2 holds the real part of butterfly 1. Lane 3 holds the imaginary part of butterfly 1. Loads use only the low 16 bits of each lane. Stores place a 16-bit value sign-extended to 32 bits in each lane.
- R5: Each R component is the 16-bit two's-complement sum of the matching A and B components, wrapping on overflow.
- R6: With D = A − B, the real part of S is Dr·Cr − Di·Ci and the imaginary part is Dr·Ci + Di·Cr. The twiddle is Q1.15. The exact sum of products is increased by 2^14, shifted right arithmetically by 15, and its low 16 bits are kept.
- R7: The twiddle for butterfly 0 is driven on `tw_re`/`tw_im` during steps 0 and 1 of the pass that follows the loading of its operands. The twiddle for butterfly 1 is driven during steps 2 and 3 of that same pass.
- R8: Operands loaded in pass n have their R pair stored by step 2 of pass n+2 and their S pair stored by step 3 of pass n+2. `st_valid` and `st_data` show the stored word in the cycle after the store step is accepted, and `st_valid` is low after every other cycle.
- R9: Dr and Di are wrapped to 16 bits before they are multiplied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_valid | input | 1 | A step command is presented this cycle |
| step_cmd | input | 2 | Step code: 0 load A, 1 load B, 2 store R, 3 store S |
| ld_data | input | 128 | Load word for steps 0 and 1 |
| tw_re | input | 16 | Twiddle real part, Q1.15 |
| tw_im | input | 16 | Twiddle imaginary part, Q1.15 |
| st_valid | output | 1 | Store word valid |
| st_data | output | 128 | Store word: R pair or S pair |
| seq_err | output | 1 | The previous cycle's step was out of order |

## Verification
The bench first runs passes on all-zero buffers and checks that the stores are zero. It then uses a unit twiddle (0x7FFF, 0) and a pure imaginary twiddle (0, 0x7FFF), which swap the real and imaginary product terms and so show whether each multiplier is wired to the right twiddle half. A negative twiddle and mixed-sign operands test rounding and the sign extension of stored lanes. Operands chosen to overflow both the sum and the difference show that R wraps and that D is wrapped before it is multiplied. Loads with non-zero upper lane bits show that those bits are ignored. In one pass, out-of-order steps and idle cycles are inserted; the results of that pass and the next must be unchanged, which proves that the rejected steps had no effect.

// File: rtl/bfly2_pkg.sv
package bfly2_pkg;
  // Step codes; the order of acceptance is 0,1,2,3 and the code equals the
  // output component index computed in that step.
  typedef enum logic [1:0] {
    CMD_LOAD_A  = 2'd0,
    CMD_LOAD_B  = 2'd1,
    CMD_STORE_R = 2'd2,
    CMD_STORE_S = 2'd3
  } bfly_cmd_e;

  localparam int unsigned NCOMP = 4;  // components per 128-bit word
endpackage

// File: rtl/bfly2_rstsync.sv
module bfly2_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/bfly2_seq.sv
module bfly2_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step_valid,
  input  logic [1:0] step_cmd,
  output logic       step_acc,
  output logic       seq_err
);
  logic [1:0] exp_q, exp_d;
  logic       err_d;

  always_comb begin
    step_acc = step_valid && (step_cmd == exp_q);
    exp_d    = step_acc ? exp_q + 2'd1 : exp_q;
    err_d    = step_valid && !step_acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q   <= 2'd0;
      seq_err <= 1'b0;
    end else begin
      exp_q   <= exp_d;
      seq_err <= err_d;
    end
  end
endmodule

// File: rtl/bfly2_math.sv
module bfly2_math #(
  parameter int unsigned DW   = 16,
  parameter int unsigned FRAC = 15
) (
  input  logic signed [DW-1:0] a_re,
  input  logic signed [DW-1:0] a_im,
  input  logic signed [DW-1:0] b_re,
  input  logic signed [DW-1:0] b_im,
  input  logic signed [DW-1:0] c_re,
  input  logic signed [DW-1:0] c_im,
  input  logic                 sel_im,
  output logic        [DW-1:0] r_out,
  output logic        [DW-1:0] s_out
);
  localparam int unsigned PW = 2 * DW;
  localparam int unsigned SW = PW + 1;
  localparam logic signed [SW-1:0] HALF = {{(SW-1){1'b0}}, 1'b1} << (FRAC - 1);

  logic signed [DW-1:0] d_re, d_im, mul0_k, mul1_k;
  logic signed [PW-1:0] prod0, prod1;
  logic signed [SW-1:0] acc;

  always_comb begin
    d_re   = a_re - b_re;                // wraps to DW bits
    d_im   = a_im - b_im;
    mul0_k = sel_im ? c_im : c_re;       // multiplier 0 always takes d_re
    mul1_k = sel_im ? c_re : c_im;       // multiplier 1 always takes d_im
    prod0  = d_re * mul0_k;
    prod1  = d_im * mul1_k;
    acc    = sel_im ? (SW'(prod0) + SW'(prod1)) : (SW'(prod0) - SW'(prod1));
    s_out  = DW'((acc + HALF) >>> FRAC);
    r_out  = sel_im ? DW'(a_im + b_im) : DW'(a_re + b_re);
  end
endmodule

// File: rtl/bfly2_pipe.sv
module bfly2_pipe
  import bfly2_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned LANE = 32,
  parameter int unsigned FRAC = 15
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   step_valid,
  input  logic [1:0]             step_cmd,
  input  logic [NCOMP*LANE-1:0]  ld_data,
  input  logic [DW-1:0]          tw_re,
  input  logic [DW-1:0]          tw_im,
  output logic                   st_valid,
  output logic [NCOMP*LANE-1:0]  st_data,
  output logic                   seq_err
);
  localparam int unsigned NC = NCOMP;
  localparam int unsigned WW = NC * LANE;
  localparam int unsigned XW = LANE - DW;

  typedef logic [NC-1:0][DW-1:0]   comp_t;
  typedef logic [NC-2:0][DW-1:0]   part_t;

  logic rst_q_n;
  logic step_acc;
  logic en_lda, en_ldb, en_str, en_sts;
  logic bsel;

  comp_t ld_comp;
  logic [NC*XW-1:0] ld_unused_hi;

  comp_t sh_a_q, sh_a_d, sh_b_q, sh_b_d;   // input shadow stage
  comp_t wk_a_q, wk_a_d, wk_b_q, wk_b_d;   // working operands
  part_t part_r_q, part_r_d, part_s_q, part_s_d;
  comp_t ob_r_q, ob_r_d, ob_s_q, ob_s_d;   // result buffer
  logic [WW-1:0] st_r_wide, st_s_wide, st_data_d;
  logic          st_valid_d;
  logic [DW-1:0] r_part, s_part;

  bfly2_rstsync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  bfly2_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .step_valid (step_valid),
    .step_cmd   (step_cmd),
    .step_acc   (step_acc),
    .seq_err    (seq_err)
  );

  // Step code selects butterfly (bit 1) and real/imag component (bit 0).
  assign bsel = step_cmd[1];

  bfly2_math #(.DW(DW), .FRAC(FRAC)) u_math (
    .a_re   (wk_a_q[{bsel, 1'b0}]),
    .a_im   (wk_a_q[{bsel, 1'b1}]),
    .b_re   (wk_b_q[{bsel, 1'b0}]),
    .b_im   (wk_b_q[{bsel, 1'b1}]),
    .c_re   (tw_re),
    .c_im   (tw_im),
    .sel_im (step_cmd[0]),
    .r_out  (r_part),
    .s_out  (s_part)
  );

  // Lane unpack / pack
  always_comb begin
    for (int k = 0; k < NC; k++) begin
      ld_comp[k]                 = ld_data[k*LANE +: DW];
      ld_unused_hi[k*XW +: XW]   = ld_data[k*LANE+DW +: XW];
      st_r_wide[k*LANE +: LANE]  = {{XW{ob_r_q[k][DW-1]}}, ob_r_q[k]};
      st_s_wide[k*LANE +: LANE]  = {{XW{ob_s_q[k][DW-1]}}, ob_s_q[k]};
    end
  end

  // Clock enables
  always_comb begin
    en_lda = step_acc && (step_cmd == CMD_LOAD_A);
    en_ldb = step_acc && (step_cmd == CMD_LOAD_B);
    en_str = step_acc && (step_cmd == CMD_STORE_R);
    en_sts = step_acc && (step_cmd == CMD_STORE_S);
  end

  // Next-state
  always_comb begin
    sh_a_d = en_lda ? ld_comp : sh_a_q;
    sh_b_d = en_ldb ? ld_comp : sh_b_q;
    wk_a_d = en_sts ? sh_a_q  : wk_a_q;
    wk_b_d = en_sts ? sh_b_q  : wk_b_q;

    part_r_d = part_r_q;
    part_s_d = part_s_q;
    for (int k = 0; k < NC - 1; k++) begin
      if (step_acc && (step_cmd == 2'(k))) begin
        part_r_d[k] = r_part;
        part_s_d[k] = s_part;
      end
    end

    ob_r_d = en_sts ? {r_part, part_r_q} : ob_r_q;
    ob_s_d = en_sts ? {s_part, part_s_q} : ob_s_q;

    st_valid_d = en_str || en_sts;
    if (en_str)      st_data_d = st_r_wide;
    else if (en_sts) st_data_d = st_s_wide;
    else             st_data_d = st_data;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      sh_a_q   <= '0;
      sh_b_q   <= '0;
      wk_a_q   <= '0;
      wk_b_q   <= '0;
      part_r_q <= '0;
      part_s_q <= '0;
      ob_r_q   <= '0;
      ob_s_q   <= '0;
      st_valid <= 1'b0;
      st_data  <= '0;
    end else begin
      sh_a_q   <= sh_a_d;
      sh_b_q   <= sh_b_d;
      wk_a_q   <= wk_a_d;
      wk_b_q   <= wk_b_d;
      part_r_q <= part_r_d;
      part_s_q <= part_s_d;
      ob_r_q   <= ob_r_d;
      ob_s_q   <= ob_s_d;
      st_valid <= st_valid_d;
      st_data  <= st_data_d;
    end
  end
endmodule

// File: rtl/bfly2_pipe_chk.sv
module bfly2_pipe_chk #(
  parameter int unsigned DW   = 16,
  parameter int unsigned LANE = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step_valid,
  input logic [1:0]        step_cmd,
  input logic              st_valid,
  input logic [4*LANE-1:0] st_data,
  input logic              seq_err
);
  logic [1:0] chk_exp;
  logic       good, bad;

  assign good = step_valid && (step_cmd == chk_exp);
  assign bad  = step_valid && (step_cmd != chk_exp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    chk_exp <= 2'd0;
    else if (good) chk_exp <= chk_exp + 2'd1;
  end

  p_err_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> seq_err) else $error("p_err_flag_r3");

  p_err_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bad |=> !seq_err) else $error("p_err_quiet_r3");

  p_hold_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> ($stable(st_data) && !st_valid)) else $error("p_hold_reject_r3");

  p_store_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (good && step_cmd[1]) |=> st_valid) else $error("p_store_valid_r8");

  p_store_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(good && step_cmd[1]) |=> !st_valid) else $error("p_store_quiet_r2");

  for (genvar g = 0; g < 4; g++) begin : g_lane
    p_sign_ext_r4: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid |-> ((st_data[g*LANE+DW-1 +: LANE-DW+1] == '0) ||
                    (st_data[g*LANE+DW-1 +: LANE-DW+1] == '1)))
      else $error("p_sign_ext_r4");
  end
endmodule

bind bfly2_pipe bfly2_pipe_chk #(.DW(DW), .LANE(LANE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .step_valid (step_valid),
  .step_cmd   (step_cmd),
  .st_valid   (st_valid),
  .st_data    (st_data),
  .seq_err    (seq_err)
);

// File: tb/bfly2_pipe_tb.sv
`timescale 1ns/1ps
module bfly2_pipe_tb;
  logic         clk;
  logic         rst_n;
  logic         step_valid;
  logic [1:0]   step_cmd;
  logic [127:0] ld_data;
  logic [15:0]  tw_re, tw_im;
  logic         st_valid;
  logic [127:0] st_data;
  logic         seq_err;

  int n_chk, n_fail;
  bit done;

  logic         s_valid, s_err;
  logic [127:0] s_data;

  // model state
  logic [3:0][15:0] m_pend_a, m_pend_b;
  logic [127:0]     m_ob_r, m_ob_s;

  localparam logic [127:0] JUNK = 128'hDEAD_BEEF_0BAD_F00D_1234_5678_9ABC_DEF0;

  bfly2_pipe u_dut (
    .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .step_cmd(step_cmd),
    .ld_data(ld_data), .tw_re(tw_re), .tw_im(tw_im),
    .st_valid(st_valid), .st_data(st_data), .seq_err(seq_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] cmd, input logic [127:0] ld,
                      input logic [15:0] cr, input logic [15:0] ci);
    @(negedge clk);
    step_valid = 1'b1;
    step_cmd   = cmd;
    ld_data    = ld;
    tw_re      = cr;
    tw_im      = ci;
    @(posedge clk);
    #2;
    s_valid    = st_valid;
    s_data     = st_data;
    s_err      = seq_err;
    step_valid = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
    step_valid = 1'b0;
    ld_data    = JUNK;
    @(posedge clk);
    #2;
    s_valid = st_valid;
    s_data  = st_data;
    s_err   = seq_err;
  endtask

  // Butterfly reference written from the requirement formulas
  task automatic model_bfly(input logic [3:0][15:0] a, input logic [3:0][15:0] b,
                            input logic [15:0] t0r, input logic [15:0] t0i,
                            input logic [15:0] t1r, input logic [15:0] t1i,
                            output logic [127:0] rw, output logic [127:0] sw);
    for (int bf = 0; bf < 2; bf++) begin
      shortint ar, ai, br, bi, cr, ci, dr, di, rr, ri, xr, xi;
      longint  sr, si;
      ar = a[2*bf];  ai = a[2*bf+1];
      br = b[2*bf];  bi = b[2*bf+1];
      cr = (bf == 0) ? t0r : t1r;
      ci = (bf == 0) ? t0i : t1i;
      dr = ar - br;
      di = ai - bi;
      rr = ar + br;
      ri = ai + bi;
      sr = (longint'(dr) * cr - longint'(di) * ci + 64'sd16384) >>> 15;
      si = (longint'(dr) * ci + longint'(di) * cr + 64'sd16384) >>> 15;
      xr = shortint'(sr);
      xi = shortint'(si);
      rw[(2*bf)*32 +: 32]   = 32'(int'(rr));
      rw[(2*bf+1)*32 +: 32] = 32'(int'(ri));
      sw[(2*bf)*32 +: 32]   = 32'(int'(xr));
      sw[(2*bf+1)*32 +: 32] = 32'(int'(xi));
    end
  endtask

  // One full pass; bad_steps inserts rejected commands and idle cycles.
  task automatic run_pass(input logic [127:0] wa, input logic [127:0] wb,
                          input logic [15:0] c0r, input logic [15:0] c0i,
                          input logic [15:0] c1r, input logic [15:0] c1i,
                          input bit bad_steps, input string tag);
    logic [127:0] exp_r, exp_s, nr, ns;
    exp_r = m_ob_r;
    exp_s = m_ob_s;

    step(2'd0, wa, c0r, c0i);
    chk(!s_valid && !s_err, {tag, " R2 load-A step no store"}, {s_valid, s_err}, 0);
    if (bad_steps) begin
      step(2'd0, JUNK, 16'h1111, 16'h2222);
      chk(s_err && !s_valid, {tag, " R3 repeated load-A rejected"}, {s_valid, s_err}, 1);
      idle();
      chk(!s_err && !s_valid, {tag, " R2 idle cycle quiet"}, {s_valid, s_err}, 0);
    end
    step(2'd1, wb, c0r, c0i);
    chk(!s_valid && !s_err, {tag, " R2 load-B step no store"}, {s_valid, s_err}, 0);
    step(2'd2, JUNK, c1r, c1i);
    chk(s_valid && !s_err, {tag, " R8 R store valid"}, {s_valid, s_err}, 2);
    chk(s_data == exp_r, {tag, " R5 R pair"}, s_data, exp_r);
    if (bad_steps) begin
      step(2'd2, JUNK, 16'h3333, 16'h4444);
      chk(s_err && !s_valid, {tag, " R3 repeated store-R rejected"}, {s_valid, s_err}, 1);
      chk(s_data == exp_r, {tag, " R3 st_data held"}, s_data, exp_r);
    end
    step(2'd3, JUNK, c1r, c1i);
    chk(s_valid && !s_err, {tag, " R8 S store valid"}, {s_valid, s_err}, 2);
    chk(s_data == exp_s, {tag, " R6 S pair"}, s_data, exp_s);

    model_bfly(m_pend_a, m_pend_b, c0r, c0i, c1r, c1i, nr, ns);
    m_ob_r = nr;
    m_ob_s = ns;
    for (int k = 0; k < 4; k++) begin
      m_pend_a[k] = wa[k*32 +: 16];   // R4: only low 16 bits of a lane load
      m_pend_b[k] = wb[k*32 +: 16];
    end
  endtask

  function automatic logic [127:0] word4(input logic [15:0] x0r, input logic [15:0] x0i,
                                         input logic [15:0] x1r, input logic [15:0] x1i);
    return {16'h0, x1i, 16'h0, x1r, 16'h0, x0i, 16'h0, x0r};
  endfunction

  task automatic t_reset();
    chk(st_valid == 1'b0 && seq_err == 1'b0, "R1 reset flags", {st_valid, seq_err}, 0);
    chk(st_data == '0, "R1 reset st_data", st_data, 0);
  endtask

  task automatic t_start_zero();
    // Stores in the first two passes come from reset-zero buffers (R1)
    run_pass(word4(16'd100, 16'd200, -16'sd300, 16'd400),
             word4(16'd10, -16'sd20, 16'd30, 16'd40),
             16'h7FFF, 16'h0000, 16'h0000, 16'h7FFF, 1'b0, "R1 pass1");
    run_pass(word4(16'd1234, -16'sd1234, 16'd5000, 16'd7),
             word4(-16'sd999, 16'd888, 16'd1, -16'sd2),
             16'h7FFF, 16'h0000, 16'h0000, 16'h7FFF, 1'b0, "R1 pass2 R7");
  endtask

  task automatic t_patterns();
    run_pass(word4(16'h7FFF, 16'h0001, 16'h8000, 16'h4000),
             word4(16'h0001, 16'h7FFF, 16'h7FFF, 16'hC000),
             16'h8000, 16'h0000, 16'h5A82, 16'hA57E, 1'b0, "R6 neg twiddle");
    run_pass(word4(16'h7FFF, 16'h8000, 16'h0003, 16'hFFFD),
             word4(16'h8000, 16'h7FFF, 16'h0001, 16'h0001),
             16'h7FFF, 16'h0000, 16'h4000, 16'h4000, 1'b0, "R9 diff wrap");
  endtask

  task automatic t_lanes();
    run_pass(128'hABCD_0010_1234_FFF0_5555_8001_AAAA_7FF0,
             128'hFFFF_0005_0000_0006_FFFF_FFFF_1111_0002,
             16'h2000, 16'hE000, 16'h7FFF, 16'h8001, 1'b0, "R4 upper lane bits");
  endtask

  task automatic t_order();
    step(2'd2, JUNK, 16'h0, 16'h0);  // expected load-A
    chk(s_err && !s_valid, "R3 store-R while load-A expected", {s_valid, s_err}, 1);
    run_pass(word4(-16'sd5000, 16'd6000, 16'd700, -16'sd800),
             word4(16'd250, 16'd250, -16'sd900, 16'd1000),
             16'h6000, 16'h3000, 16'hD000, 16'h7000, 1'b1, "R3 injected");
    run_pass(word4(16'd1, 16'd2, 16'd3, 16'd4), word4(16'd5, 16'd6, 16'd7, 16'd8),
             16'h7FFF, 16'h7FFF, 16'h8000, 16'h8000, 1'b0, "R8 after inject");
  endtask

  task automatic t_drain();
    run_pass('0, '0, 16'h1234, 16'h4321, 16'hF00F, 16'h0FF0, 1'b0, "R8 drain1");
    run_pass('0, '0, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0, "R8 drain2");
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; step_valid = 1'b0; step_cmd = '0; ld_data = '0;
    tw_re = '0; tw_im = '0;
    m_pend_a = '0; m_pend_b = '0; m_ob_r = '0; m_ob_s = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_start_zero();
    t_patterns();
    t_lanes();
    t_order();
    t_drain();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL R8 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule